// File: doc/BRIEF.md
# Read-Priority Line Request Queue

This block sits between a cache and the system bus and decides which memory request goes out next. Cached line reads wait in a small read queue. Posted writes wait in a small write buffer. An access to an uncached page waits in a single slot of its own. A read stalls the processor, so a read that is ready always goes out before any buffered write or uncached access. A write counts as complete the moment it is accepted into the buffer, so the processor never waits on the bus for a write.

Reads take priority, so a read could overtake a buffered write to the same memory line and fetch stale data. To prevent this, every cached read is compared against the write buffer at line granularity when it is accepted. If the line matches, the read is flagged. It then stays at the head of its queue until the youngest matching write, and every write older than it, has been issued. One valid/ready port carries every request to the bus. Once a request is presented, it stays unchanged until the bus accepts it.

Top module: `line_req_arbiter`

## Requirements
- R1: The read queue holds two cached reads. `rd_ready` for a cached read (`rd_uncached`=0) is low while two reads are pending and high otherwise.
- R2: The write buffer holds three cached writes. `wr_ready` for a cached write is low while three writes are buffered.
- R3: When no request is held on the bus, a pending read whose conflict wait is clear is presented ahead of any buffered write and any uncached access.
- R4: A cached write is accepted whenever the buffer has room, even while the bus is stalled. Acceptance is its completion.
- R5: `rd_conflict` is high in the cycle a cached read is accepted, if its line matches a buffered write. Otherwise it is low.
- R6: A flagged read is not issued until the youngest matching write and all older writes have been issued. It is issued before any younger write.
- R7: Buffered writes reach the bus in the order they were accepted, each with its own data.
- R8: The line compare uses address bits 31 down to 5 (32-byte lines). A read at 0x51C matches a write at 0x500. A read at 0x720 does not match a write at 0x700.
- R9: Uncached reads and writes use a separate one-entry slot and appear with `bus_uncached`=1. The slot goes after ready reads and ahead of buffered writes. While it is occupied, `rd_ready` and `wr_ready` are low for uncached requests.
- R10: Cached reads reach the bus in arrival order.
- R11: After reset, all queues are empty, `bus_valid` is low, and both ready outputs are high.
- R12: While `bus_valid` is high and `bus_ready` is low, the presented address, direction and uncached flag stay unchanged, even if a read arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | 32 | Read byte address |
| rd_uncached | input | 1 | Read targets an uncached page |
| rd_conflict | output | 1 | Accepted cached read matches a buffered write line |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be accepted (acceptance means complete) |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 64 | Write data |
| wr_uncached | input | 1 | Write targets an uncached page |
| bus_valid | output | 1 | A request is presented to the bus |
| bus_ready | input | 1 | Bus accepts the presented request |
| bus_write | output | 1 | Presented request is a write |
| bus_uncached | output | 1 | Presented request comes from the uncached slot |
| bus_addr | output | 32 | Presented address |
| bus_data | output | 64 | Presented write data (zero for reads) |

## Verification
The hardest case to reach is a flagged read that sits at the head of the read queue, blocked, while writes drain around it. The read must then go out exactly between the matching write and the next younger one. The bench builds this with the bus stalled. It fills the write buffer with three lines, then sends a read that hits the middle entry at a non-zero offset. It then releases the bus one transfer at a time and checks each presented request. A similar stalled-bus pattern keeps a write held on the bus while a read arrives. This checks that the held request is not preempted, and that the read wins once the bus accepts the held write.

// File: rtl/line_req_arbiter.sv
module line_req_arbiter #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int RD_DEPTH = 2,
  parameter int WR_DEPTH = 3,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_uncached,
  output logic          rd_conflict,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_uncached,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic          bus_uncached,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int RCW = $clog2(RD_DEPTH + 1);
  localparam int CW  = $clog2(WR_DEPTH + 1);
  localparam int RIW = $clog2(RD_DEPTH);
  localparam int WIW = $clog2(WR_DEPTH);

  typedef enum logic [1:0] {S_NONE, S_RD, S_UC, S_WR} sel_t;

  logic [AW-1:0] rq_addr [RD_DEPTH];
  logic [CW-1:0] rq_wait [RD_DEPTH];
  logic [RCW-1:0] rq_n;
  logic [AW-1:0] wq_addr [WR_DEPTH];
  logic [DW-1:0] wq_data [WR_DEPTH];
  logic [CW-1:0] wq_n;
  logic          uc_full, uc_write;
  logic [AW-1:0] uc_addr;
  logic [DW-1:0] uc_data;
  logic          hold_q;
  sel_t          hold_sel_q, sel;
  logic [CW-1:0] need;

  assign rd_ready = rd_uncached ? !uc_full : (rq_n != RCW'(RD_DEPTH));
  assign wr_ready = wr_uncached ? (!uc_full && !(rd_valid && rd_uncached))
                                : (wq_n != CW'(WR_DEPTH));

  wire rd_take = rd_valid && rd_ready && !rd_uncached;
  wire wr_take = wr_valid && wr_ready && !wr_uncached;
  wire uc_rd_take = rd_valid && rd_ready && rd_uncached;
  wire uc_wr_take = wr_valid && wr_ready && wr_uncached;

  always_comb begin
    need = '0;
    for (int i = 0; i < WR_DEPTH; i++)
      if (CW'(i) < wq_n && wq_addr[i][AW-1:OFS] == rd_addr[AW-1:OFS])
        need = CW'(i + 1);
  end
  assign rd_conflict = rd_take && (need != '0);

  always_comb begin
    if (hold_q) sel = hold_sel_q;
    else if (rq_n != '0 && rq_wait[0] == '0) sel = S_RD;
    else if (uc_full) sel = S_UC;
    else if (wq_n != '0) sel = S_WR;
    else sel = S_NONE;
  end

  assign bus_valid    = (sel != S_NONE);
  assign bus_write    = (sel == S_WR) || (sel == S_UC && uc_write);
  assign bus_uncached = (sel == S_UC);
  assign bus_addr = (sel == S_RD) ? rq_addr[0] : (sel == S_UC) ? uc_addr :
                    (sel == S_WR) ? wq_addr[0] : '0;
  assign bus_data = (sel == S_WR) ? wq_data[0] : (sel == S_UC) ? uc_data : '0;

  wire fire   = bus_valid && bus_ready;
  wire rd_pop = fire && sel == S_RD;
  wire uc_pop = fire && sel == S_UC;
  wire wr_pop = fire && sel == S_WR;

  wire [RIW-1:0] rq_idx = RIW'(rq_n - RCW'(rd_pop));
  wire [WIW-1:0] wq_idx = WIW'(wq_n - CW'(wr_pop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_n <= '0;
      for (int i = 0; i < RD_DEPTH; i++) begin
        rq_addr[i] <= '0;
        rq_wait[i] <= '0;
      end
    end else begin
      if (rd_pop) begin
        for (int i = 0; i < RD_DEPTH - 1; i++) begin
          rq_addr[i] <= rq_addr[i+1];
          rq_wait[i] <= rq_wait[i+1];
        end
      end else if (wr_pop) begin
        for (int i = 0; i < RD_DEPTH; i++)
          if (rq_wait[i] != '0) rq_wait[i] <= rq_wait[i] - 1'b1;
      end
      if (rd_take) begin
        rq_addr[rq_idx] <= rd_addr;
        rq_wait[rq_idx] <= (wr_pop && need != '0) ? need - 1'b1 : need;
      end
      rq_n <= rq_n + RCW'(rd_take) - RCW'(rd_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wq_n <= '0;
      for (int i = 0; i < WR_DEPTH; i++) begin
        wq_addr[i] <= '0;
        wq_data[i] <= '0;
      end
    end else begin
      if (wr_pop)
        for (int i = 0; i < WR_DEPTH - 1; i++) begin
          wq_addr[i] <= wq_addr[i+1];
          wq_data[i] <= wq_data[i+1];
        end
      if (wr_take) begin
        wq_addr[wq_idx] <= wr_addr;
        wq_data[wq_idx] <= wr_data;
      end
      wq_n <= wq_n + CW'(wr_take) - CW'(wr_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uc_full <= 1'b0;
      uc_write <= 1'b0;
      uc_addr <= '0;
      uc_data <= '0;
      hold_q <= 1'b0;
      hold_sel_q <= S_NONE;
    end else begin
      if (uc_rd_take) begin
        uc_full <= 1'b1;
        uc_write <= 1'b0;
        uc_addr <= rd_addr;
        uc_data <= '0;
      end else if (uc_wr_take) begin
        uc_full <= 1'b1;
        uc_write <= 1'b1;
        uc_addr <= wr_addr;
        uc_data <= wr_data;
      end else if (uc_pop) begin
        uc_full <= 1'b0;
      end
      hold_q <= bus_valid && !bus_ready;
      hold_sel_q <= sel;
    end
  end

  assert_rd_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_n == RCW'(RD_DEPTH) && !rd_uncached) |-> !rd_ready);
  assert_wr_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_n == CW'(WR_DEPTH) && !wr_uncached) |-> !wr_ready);
  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_n != '0) |-> (rq_wait[0] <= wq_n));
  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> (rq_wait[0] == '0));
  assert_uc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uc_full && rd_uncached) |-> !rd_ready);
  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_write) && $stable(bus_uncached)));
endmodule

// File: tb/line_req_arbiter_test.sv
module line_req_arbiter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 0, rd_uncached = 0, wr_valid = 0, wr_uncached = 0, bus_ready = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic rd_ready, rd_conflict, wr_ready, bus_valid, bus_write, bus_uncached;
  logic [31:0] bus_addr;
  logic [63:0] bus_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  line_req_arbiter uut (.*);

  function automatic logic [63:0] dat(input logic [31:0] a);
    return {a, ~a} ^ 64'h5A5A_0F0F_3C3C_A5A5;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push_wr(input logic [31:0] a, input logic uc, input string tag);
    wr_valid = 1; wr_addr = a; wr_data = dat(a); wr_uncached = uc; #1;
    chk({tag, " wr_ready"}, wr_ready, 1);
    step();
    wr_valid = 0; wr_uncached = 0;
  endtask

  task automatic push_rd(input logic [31:0] a, input logic uc, input logic cf, input string tag);
    rd_valid = 1; rd_addr = a; rd_uncached = uc; #1;
    chk({tag, " rd_ready"}, rd_ready, 1);
    chk({tag, " rd_conflict"}, rd_conflict, cf);
    step();
    rd_valid = 0; rd_uncached = 0;
  endtask

  task automatic take(input logic w, input logic uc, input logic [31:0] a, input string tag);
    chk({tag, " bus_valid"}, bus_valid, 1);
    chk({tag, " bus_write"}, bus_write, w);
    chk({tag, " bus_uncached"}, bus_uncached, uc);
    chk({tag, " bus_addr"}, bus_addr, a);
    if (w) chk({tag, " bus_data"}, bus_data, dat(a));
    bus_ready = 1;
    step();
    bus_ready = 0;
  endtask

  task automatic t_reset();
    chk("R11 bus_valid", bus_valid, 0);
    chk("R11 rd_ready", rd_ready, 1);
    chk("R11 wr_ready", wr_ready, 1);
  endtask

  task automatic t_priority();
    push_wr(32'h100, 0, "R4 w0");
    push_wr(32'h200, 0, "R4 w1 while bus stalled");
    push_wr(32'h300, 0, "R2 w2");
    #1 chk("R2 wr_ready full", wr_ready, 0);
    push_rd(32'h1000, 0, 0, "R3 read");
    chk("R12 held write addr", bus_addr, 32'h100);
    chk("R12 held write dir", bus_write, 1);
    take(1, 0, 32'h100, "R12 w0");
    take(0, 0, 32'h1000, "R3 read first");
    take(1, 0, 32'h200, "R7 w1");
    take(1, 0, 32'h300, "R7 w2");
    chk("R7 drained", bus_valid, 0);
  endtask

  task automatic t_read_queue();
    push_rd(32'h2000, 0, 0, "R10 ra");
    push_rd(32'h3000, 0, 0, "R10 rb");
    #1 chk("R1 rd_ready full", rd_ready, 0);
    take(0, 0, 32'h2000, "R10 ra");
    chk("R1 rd_ready after pop", rd_ready, 1);
    take(0, 0, 32'h3000, "R10 rb");
    chk("R10 drained", bus_valid, 0);
  endtask

  task automatic t_conflict();
    push_wr(32'h400, 0, "R6 w400");
    push_wr(32'h500, 0, "R6 w500");
    push_wr(32'h600, 0, "R6 w600");
    push_rd(32'h51C, 0, 1, "R5 R8 match mid line");
    take(1, 0, 32'h400, "R6 w400");
    take(1, 0, 32'h500, "R6 matching write before read");
    take(0, 0, 32'h51C, "R6 read before younger write");
    take(1, 0, 32'h600, "R6 w600");
    push_wr(32'h700, 0, "R8 w700");
    push_rd(32'h720, 0, 0, "R8 next line no match");
    take(1, 0, 32'h700, "R8 w700");
    take(0, 0, 32'h720, "R8 r720");
    chk("R8 drained", bus_valid, 0);
  endtask

  task automatic t_uncached();
    push_wr(32'h800, 0, "R9 w800");
    push_wr(32'h900, 1, "R9 uc write");
    rd_uncached = 1; wr_uncached = 1; #1;
    chk("R9 rd_ready uc full", rd_ready, 0);
    chk("R9 wr_ready uc full", wr_ready, 0);
    rd_uncached = 0; wr_uncached = 0;
    push_rd(32'hA00, 0, 0, "R9 cached read");
    push_wr(32'h880, 0, "R9 w880");
    take(1, 0, 32'h800, "R9 w800");
    take(0, 0, 32'hA00, "R3 read before uc");
    take(1, 1, 32'h900, "R9 uc before buffered write");
    take(1, 0, 32'h880, "R9 w880");
    push_rd(32'hB04, 1, 0, "R9 uc read");
    take(0, 1, 32'hB04, "R9 uc read");
    chk("R9 drained", bus_valid, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_priority();
    t_read_queue();
    t_conflict();
    t_uncached();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule